// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit CPU Core

This block turns a decoded instruction into the address its operand comes from. For each request it reports the operand address, whether an address exists, the branch destination, whether the branch is taken, and the total length of the instruction in bytes. A request comes from the decode stage. It carries the addressing mode, a flag that says an extra leading prebyte is present, a selector between the two index registers, and the up to two operand bytes that follow the opcode. It also carries the address of the instruction's first byte, the contents of both 16-bit index registers, and the evaluated branch condition.

A single-cycle strobe qualifies each request, and the block captures it into an input register. All results are computed combinationally from that register. With the default configuration they appear together with a one-cycle response strobe on the clock after the request. A parameter can add an output register, which costs one more cycle of latency. Every result output reads zero whenever the response strobe is low. Opcode decoding, fetch sequencing and cycle timing of the core are left to the surrounding logic.

Top module: `eff_addr_gen`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_valid` high for exactly one cycle, one clock later (two clocks when `OUT_REG`=1). While `rsp_valid` is low, `rsp_ea`, `rsp_ea_valid`, `rsp_br_target`, `rsp_br_taken` and `rsp_len` are all zero. Inputs presented with `req_valid` low produce no response.
- R2: Direct mode (code 1) gives an address whose high byte is 0x00 and whose low byte is `req_op0`.
- R3: Extended mode (code 2) gives the address {`req_op0`, `req_op1`}, with the first operand byte as the high byte.
- R4: Indexed mode (code 3) gives the zero-extended `req_op0` plus IX when `req_sel_iy`=0, or plus IY when it is 1. The sum wraps modulo 65536.
- R5: Relative mode (code 5) with `req_br_cond`=1 sets `rsp_br_taken` and gives a target equal to `req_pc` + `rsp_len` + the sign-extended `req_op0`, modulo 65536. With the condition false, the target is `req_pc` + `rsp_len` and taken is 0. In both cases `rsp_ea` equals the target and `rsp_ea_valid` is 1.
- R6: Inherent mode (code 4) and the unused codes 6 and 7 give `rsp_ea_valid`=0 and `rsp_ea`=0, and they ignore the branch condition.
- R7: Immediate mode (code 0) gives `req_pc` + 1 + `req_prebyte`, which is the byte after the opcode.
- R8: `rsp_len` is a base length plus 1 when `req_prebyte` is set. The base lengths are: immediate 2, or 3 with `req_imm_wide`; direct 2; extended 3; indexed 2; inherent 1; relative 2; unused codes 1.
- R9: For every mode other than relative, `rsp_br_target` is `req_pc` + `rsp_len` and `rsp_br_taken` is 0.
- R10: During reset and after it, with no request, `rsp_valid` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_mode | input | 3 | Addressing mode code (see R2 to R7) |
| req_prebyte | input | 1 | Instruction carries a prebyte |
| req_sel_iy | input | 1 | Indexed mode uses IY instead of IX |
| req_imm_wide | input | 1 | Immediate operand is two bytes |
| req_br_cond | input | 1 | Branch condition is true |
| req_op0 | input | 8 | First byte after the opcode |
| req_op1 | input | 8 | Second byte after the opcode |
| req_pc | input | 16 | Address of the instruction's first byte |
| req_ix | input | 16 | Index register X |
| req_iy | input | 16 | Index register Y |
| rsp_valid | output | 1 | Result strobe |
| rsp_ea | output | 16 | Effective address |
| rsp_ea_valid | output | 1 | The mode produces a memory address |
| rsp_br_target | output | 16 | Branch target or next sequential address |
| rsp_br_taken | output | 1 | Relative branch taken |
| rsp_len | output | 3 | Instruction length in bytes |

## Verification
On every cycle, the bound checker checks the following:
- the response strobe follows a request by the configured latency;
- the results read zero while the strobe is low;
- direct addresses stay within page zero and extended addresses repeat the operand bytes;
- inherent and unused codes never claim an address;
- a taken branch always comes from a relative request with a true condition;
- the length stays between one and four.

The address arithmetic needs the bench's scenarios. These include the indexed sums, their wrap from 0xFFFF into page zero, and the choice between the two index registers. They also include the signed branch offsets that cross 0x0000 backward or 0xFFFF forward, the effect of a prebyte on every length and on the immediate address, and back-to-back requests.

// File: rtl/eag_pkg.sv
package eag_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      AM_IMM = 3'd0,
      AM_DIR = 3'd1,
      AM_EXT = 3'd2,
      AM_IDX = 3'd3,
      AM_INH = 3'd4,
      AM_REL = 3'd5,
      AM_RS6 = 3'd6,
      AM_RS7 = 3'd7
   } amode_e;

   localparam int MAX_LEN = 4;

endpackage

// File: rtl/eag_len_calc.sv
module eag_len_calc
   import eag_pkg::*;
#(
   parameter int LEN_W = 3
) (
   input  amode_e             mode,
   input  logic               prebyte,
   input  logic               imm_wide,
   output logic [LEN_W-1:0]   len
);

   logic [LEN_W-1:0] base_len;

   always_comb begin
      unique case (mode)
         AM_IMM:  base_len = imm_wide ? LEN_W'(3) : LEN_W'(2);
         AM_DIR:  base_len = LEN_W'(2);
         AM_EXT:  base_len = LEN_W'(3);
         AM_IDX:  base_len = LEN_W'(2);
         AM_REL:  base_len = LEN_W'(2);
         default: base_len = LEN_W'(1);
      endcase
   end

   assign len = base_len + {{(LEN_W-1){1'b0}}, prebyte};

endmodule

// File: rtl/eag_index_add.sv
module eag_index_add #(
   parameter int ADDR_W       = 16,
   parameter int BYTE_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] ix,
   input  logic [ADDR_W-1:0] iy,
   input  logic              sel_iy,
   input  logic [BYTE_W-1:0] offset,
   output logic [ADDR_W-1:0] sum
);

   localparam int PAD_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] off_ext;
   assign off_ext = {{PAD_W{1'b0}}, offset};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] base;
         assign base = sel_iy ? iy : ix;
         assign sum  = base + off_ext;
      end else begin : g_dual
         logic [ADDR_W-1:0] sum_x;
         logic [ADDR_W-1:0] sum_y;
         assign sum_x = ix + off_ext;
         assign sum_y = iy + off_ext;
         assign sum   = sel_iy ? sum_y : sum_x;
      end
   endgenerate

endmodule

// File: rtl/eag_branch_calc.sv
module eag_branch_calc #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   parameter int LEN_W  = 3
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [LEN_W-1:0]  len,
   input  logic [BYTE_W-1:0] offset,
   input  logic              is_rel,
   input  logic              cond,
   output logic [ADDR_W-1:0] target,
   output logic              taken
);

   localparam int PAD_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] next_pc;
   logic [ADDR_W-1:0] off_sext;

   assign next_pc  = pc + {{(ADDR_W-LEN_W){1'b0}}, len};
   assign off_sext = {{PAD_W{offset[BYTE_W-1]}}, offset};
   assign taken    = is_rel & cond;
   assign target   = taken ? (next_pc + off_sext) : next_pc;

endmodule

// File: rtl/eag_addr_sel.sv
module eag_addr_sel
   import eag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  amode_e            mode,
   input  logic              prebyte,
   input  logic [BYTE_W-1:0] op0,
   input  logic [BYTE_W-1:0] op1,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] idx_sum,
   input  logic [ADDR_W-1:0] br_target,
   output logic [ADDR_W-1:0] ea,
   output logic              ea_valid
);

   localparam int PAD_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] imm_addr;
   assign imm_addr = pc + {{(ADDR_W-1){1'b0}}, 1'b1} + {{(ADDR_W-1){1'b0}}, prebyte};

   always_comb begin
      ea       = '0;
      ea_valid = 1'b1;
      unique case (mode)
         AM_IMM:  ea = imm_addr;
         AM_DIR:  ea = {{PAD_W{1'b0}}, op0};
         AM_EXT:  ea = {op0, op1};
         AM_IDX:  ea = idx_sum;
         AM_REL:  ea = br_target;
         default: ea_valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
   import eag_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int BYTE_W       = 8,
   parameter bit SHARED_ADDER = 1'b1,
   parameter bit OUT_REG      = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [MODE_W-1:0]    req_mode,
   input  logic                 req_prebyte,
   input  logic                 req_sel_iy,
   input  logic                 req_imm_wide,
   input  logic                 req_br_cond,
   input  logic [BYTE_W-1:0]    req_op0,
   input  logic [BYTE_W-1:0]    req_op1,
   input  logic [ADDR_W-1:0]    req_pc,
   input  logic [ADDR_W-1:0]    req_ix,
   input  logic [ADDR_W-1:0]    req_iy,
   output logic                 rsp_valid,
   output logic [ADDR_W-1:0]    rsp_ea,
   output logic                 rsp_ea_valid,
   output logic [ADDR_W-1:0]    rsp_br_target,
   output logic                 rsp_br_taken,
   output logic [$clog2(MAX_LEN+1)-1:0] rsp_len
);

   localparam int LEN_W = $clog2(MAX_LEN + 1);

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
         $error("eff_addr_gen: ADDR_W must be twice BYTE_W");
      end
      if (LEN_W >= ADDR_W) begin : g_bad_len
         $error("eff_addr_gen: length field wider than address");
      end
   endgenerate

   // captured request
   logic              q_valid;
   amode_e            q_mode;
   logic              q_prebyte, q_sel_iy, q_imm_wide, q_cond;
   logic [BYTE_W-1:0] q_op0, q_op1;
   logic [ADDR_W-1:0] q_pc, q_ix, q_iy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid    <= 1'b0;
         q_mode     <= AM_IMM;
         q_prebyte  <= 1'b0;
         q_sel_iy   <= 1'b0;
         q_imm_wide <= 1'b0;
         q_cond     <= 1'b0;
         q_op0      <= '0;
         q_op1      <= '0;
         q_pc       <= '0;
         q_ix       <= '0;
         q_iy       <= '0;
      end else begin
         q_valid <= req_valid;
         if (req_valid) begin
            q_mode     <= amode_e'(req_mode);
            q_prebyte  <= req_prebyte;
            q_sel_iy   <= req_sel_iy;
            q_imm_wide <= req_imm_wide;
            q_cond     <= req_br_cond;
            q_op0      <= req_op0;
            q_op1      <= req_op1;
            q_pc       <= req_pc;
            q_ix       <= req_ix;
            q_iy       <= req_iy;
         end
      end
   end

   logic [LEN_W-1:0]  c_len;
   logic [ADDR_W-1:0] c_idx_sum, c_target, c_ea;
   logic              c_taken, c_ea_valid;

   eag_len_calc #(.LEN_W(LEN_W)) len_i (
      .mode     (q_mode),
      .prebyte  (q_prebyte),
      .imm_wide (q_imm_wide),
      .len      (c_len)
   );

   eag_index_add #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SHARED_ADDER(SHARED_ADDER)) idx_i (
      .ix     (q_ix),
      .iy     (q_iy),
      .sel_iy (q_sel_iy),
      .offset (q_op0),
      .sum    (c_idx_sum)
   );

   eag_branch_calc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) br_i (
      .pc     (q_pc),
      .len    (c_len),
      .offset (q_op0),
      .is_rel (q_mode == AM_REL),
      .cond   (q_cond),
      .target (c_target),
      .taken  (c_taken)
   );

   eag_addr_sel #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) sel_i (
      .mode      (q_mode),
      .prebyte   (q_prebyte),
      .op0       (q_op0),
      .op1       (q_op1),
      .pc        (q_pc),
      .idx_sum   (c_idx_sum),
      .br_target (c_target),
      .ea        (c_ea),
      .ea_valid  (c_ea_valid)
   );

   // results are forced to zero outside the strobe
   logic              g_valid, g_ea_valid, g_taken;
   logic [ADDR_W-1:0] g_ea, g_target;
   logic [LEN_W-1:0]  g_len;

   assign g_valid    = q_valid;
   assign g_ea       = q_valid ? c_ea : '0;
   assign g_ea_valid = q_valid & c_ea_valid;
   assign g_target   = q_valid ? c_target : '0;
   assign g_taken    = q_valid & c_taken;
   assign g_len      = q_valid ? c_len : '0;

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_valid     <= 1'b0;
               rsp_ea        <= '0;
               rsp_ea_valid  <= 1'b0;
               rsp_br_target <= '0;
               rsp_br_taken  <= 1'b0;
               rsp_len       <= '0;
            end else begin
               rsp_valid     <= g_valid;
               rsp_ea        <= g_ea;
               rsp_ea_valid  <= g_ea_valid;
               rsp_br_target <= g_target;
               rsp_br_taken  <= g_taken;
               rsp_len       <= g_len;
            end
         end
      end else begin : g_out_comb
         assign rsp_valid     = g_valid;
         assign rsp_ea        = g_ea;
         assign rsp_ea_valid  = g_ea_valid;
         assign rsp_br_target = g_target;
         assign rsp_br_taken  = g_taken;
         assign rsp_len       = g_len;
      end
   endgenerate

endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
   parameter int ADDR_W  = 16,
   parameter int BYTE_W  = 8,
   parameter int LEN_W   = 3,
   parameter bit OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_mode,
   input logic              req_br_cond,
   input logic [BYTE_W-1:0] req_op0,
   input logic [BYTE_W-1:0] req_op1,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_ea,
   input logic              rsp_ea_valid,
   input logic [ADDR_W-1:0] rsp_br_target,
   input logic              rsp_br_taken,
   input logic [LEN_W-1:0]  rsp_len
);

   localparam int LAT = OUT_REG ? 2 : 1;

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid, LAT));

   // R1
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_ea == '0 && !rsp_ea_valid && rsp_br_target == '0
                      && !rsp_br_taken && rsp_len == '0));

   // R2
   direct_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_mode, LAT) == 3'd1) |->
         (rsp_ea == {{(ADDR_W-BYTE_W){1'b0}}, $past(req_op0, LAT)}));

   // R3
   extended_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_mode, LAT) == 3'd2) |->
         (rsp_ea == {$past(req_op0, LAT), $past(req_op1, LAT)}));

   // R5
   taken_only_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_br_taken |-> ($past(req_mode, LAT) == 3'd5 && $past(req_br_cond, LAT)));

   // R5
   rel_ea_is_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_mode, LAT) == 3'd5) |->
         (rsp_ea == rsp_br_target && rsp_ea_valid));

   // R6
   no_addr_inherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && ($past(req_mode, LAT) == 3'd4 || $past(req_mode, LAT) >= 3'd6)) |->
         (!rsp_ea_valid && rsp_ea == '0 && !rsp_br_taken));

   // R8
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_len >= LEN_W'(1) && rsp_len <= LEN_W'(4)));

endmodule

bind eff_addr_gen eag_chk #(
   .ADDR_W  (ADDR_W),
   .BYTE_W  (BYTE_W),
   .LEN_W   ($clog2(eag_pkg::MAX_LEN + 1)),
   .OUT_REG (OUT_REG)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_mode      (req_mode),
   .req_br_cond   (req_br_cond),
   .req_op0       (req_op0),
   .req_op1       (req_op1),
   .rsp_valid     (rsp_valid),
   .rsp_ea        (rsp_ea),
   .rsp_ea_valid  (rsp_ea_valid),
   .rsp_br_target (rsp_br_target),
   .rsp_br_taken  (rsp_br_taken),
   .rsp_len       (rsp_len)
);

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic        req_prebyte = 1'b0, req_sel_iy = 1'b0, req_imm_wide = 1'b0, req_br_cond = 1'b0;
   logic [7:0]  req_op0 = '0, req_op1 = '0;
   logic [15:0] req_pc = '0, req_ix = '0, req_iy = '0;
   logic        rsp_valid, rsp_ea_valid, rsp_br_taken;
   logic [15:0] rsp_ea, rsp_br_target;
   logic [2:0]  rsp_len;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   eff_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_prebyte(req_prebyte), .req_sel_iy(req_sel_iy), .req_imm_wide(req_imm_wide),
      .req_br_cond(req_br_cond), .req_op0(req_op0), .req_op1(req_op1), .req_pc(req_pc),
      .req_ix(req_ix), .req_iy(req_iy), .rsp_valid(rsp_valid), .rsp_ea(rsp_ea),
      .rsp_ea_valid(rsp_ea_valid), .rsp_br_target(rsp_br_target),
      .rsp_br_taken(rsp_br_taken), .rsp_len(rsp_len)
   );

   typedef struct packed {
      logic [2:0]  mode;
      logic        pre;
      logic        sel;
      logic        wide;
      logic        cond;
      logic [7:0]  op0;
      logic [7:0]  op1;
      logic [15:0] pc;
      logic [15:0] ix;
      logic [15:0] iy;
      logic [15:0] ea;
      logic        eav;
      logic [15:0] tgt;
      logic        taken;
      logic [2:0]  len;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{3'd0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,16'h1000,16'h0000,16'h0000,16'h1001,1'b1,16'h1002,1'b0,3'd2}, // R7
      '{3'd0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,16'h2000,16'h0000,16'h0000,16'h2002,1'b1,16'h2004,1'b0,3'd4}, // R7
      '{3'd1,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h77,16'h3000,16'h0000,16'h0000,16'h005A,1'b1,16'h3002,1'b0,3'd2}, // R2
      '{3'd1,1'b1,1'b0,1'b0,1'b0,8'hFF,8'h00,16'h3100,16'h0000,16'h0000,16'h00FF,1'b1,16'h3103,1'b0,3'd3}, // R2
      '{3'd2,1'b0,1'b0,1'b0,1'b1,8'hC1,8'h23,16'h4000,16'h0000,16'h0000,16'hC123,1'b1,16'h4003,1'b0,3'd3}, // R3
      '{3'd2,1'b1,1'b0,1'b0,1'b0,8'h12,8'h34,16'h4100,16'h0000,16'h0000,16'h1234,1'b1,16'h4104,1'b0,3'd4}, // R3
      '{3'd3,1'b0,1'b0,1'b0,1'b0,8'h80,8'h00,16'h5000,16'h8000,16'h9000,16'h8080,1'b1,16'h5002,1'b0,3'd2}, // R4
      '{3'd3,1'b1,1'b1,1'b0,1'b0,8'h80,8'h00,16'h5000,16'h8000,16'h9000,16'h9080,1'b1,16'h5003,1'b0,3'd3}, // R4
      '{3'd3,1'b0,1'b0,1'b0,1'b0,8'h01,8'h00,16'h5200,16'hFFFF,16'h1234,16'h0000,1'b1,16'h5202,1'b0,3'd2}, // R4 wrap
      '{3'd3,1'b0,1'b1,1'b0,1'b0,8'hFF,8'h00,16'h5300,16'h0000,16'hFFF0,16'h00EF,1'b1,16'h5302,1'b0,3'd2}, // R4 wrap
      '{3'd4,1'b0,1'b0,1'b0,1'b1,8'hAA,8'h55,16'h6000,16'h1111,16'h2222,16'h0000,1'b0,16'h6001,1'b0,3'd1}, // R6
      '{3'd4,1'b1,1'b0,1'b0,1'b0,8'hAA,8'h55,16'h6000,16'h1111,16'h2222,16'h0000,1'b0,16'h6002,1'b0,3'd2}, // R6
      '{3'd5,1'b0,1'b0,1'b0,1'b1,8'h10,8'h00,16'h7000,16'h0000,16'h0000,16'h7012,1'b1,16'h7012,1'b1,3'd2}, // R5
      '{3'd5,1'b0,1'b0,1'b0,1'b1,8'h80,8'h00,16'h7000,16'h0000,16'h0000,16'h6F82,1'b1,16'h6F82,1'b1,3'd2}, // R5
      '{3'd5,1'b0,1'b0,1'b0,1'b0,8'h10,8'h00,16'h7000,16'h0000,16'h0000,16'h7002,1'b1,16'h7002,1'b0,3'd2}, // R5
      '{3'd5,1'b0,1'b0,1'b0,1'b1,8'hE0,8'h00,16'h0010,16'h0000,16'h0000,16'hFFF2,1'b1,16'hFFF2,1'b1,3'd2}, // R5 wrap
      '{3'd5,1'b0,1'b0,1'b0,1'b1,8'h7F,8'h00,16'hFFF0,16'h0000,16'h0000,16'h0071,1'b1,16'h0071,1'b1,3'd2}, // R5 wrap
      '{3'd5,1'b1,1'b0,1'b0,1'b1,8'hFE,8'h00,16'h7100,16'h0000,16'h0000,16'h7101,1'b1,16'h7101,1'b1,3'd3}, // R5 prebyte
      '{3'd6,1'b1,1'b0,1'b0,1'b1,8'h33,8'h44,16'h8000,16'h0000,16'h0000,16'h0000,1'b0,16'h8002,1'b0,3'd2}, // R6
      '{3'd7,1'b0,1'b0,1'b0,1'b0,8'h33,8'h44,16'h8000,16'h0000,16'h0000,16'h0000,1'b0,16'h8001,1'b0,3'd1}  // R6
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      req_valid    = 1'b1;
      req_mode     = v.mode;
      req_prebyte  = v.pre;
      req_sel_iy   = v.sel;
      req_imm_wide = v.wide;
      req_br_cond  = v.cond;
      req_op0      = v.op0;
      req_op1      = v.op1;
      req_pc       = v.pc;
      req_ix       = v.ix;
      req_iy       = v.iy;
   endtask

   task automatic expect_vec(input vec_t v, input int idx);
      string s;
      s = $sformatf("vector %0d", idx);
      check({s, " R1 valid"}, 32'(rsp_valid), 32'd1);
      check({s, " R2/R3/R4/R5/R7 ea"}, 32'(rsp_ea), 32'(v.ea));
      check({s, " R6 ea_valid"}, 32'(rsp_ea_valid), 32'(v.eav));
      check({s, " R5/R9 target"}, 32'(rsp_br_target), 32'(v.tgt));
      check({s, " R5/R9 taken"}, 32'(rsp_br_taken), 32'(v.taken));
      check({s, " R8 len"}, 32'(rsp_len), 32'(v.len));
   endtask

   task automatic expect_idle(input string tag);
      check({tag, " valid"}, 32'(rsp_valid), 32'd0);
      check({tag, " ea"}, 32'(rsp_ea), 32'd0);
      check({tag, " target"}, 32'(rsp_br_target), 32'd0);
      check({tag, " len"}, 32'(rsp_len), 32'd0);
   endtask

   initial begin
      // R10: reset holds everything at zero, even with a request offered
      repeat (2) @(negedge clk);
      drive(VECS[4]);
      @(negedge clk);
      expect_idle("R10 in reset");
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_idle("R10 after reset");

      // table walk, each request followed by an idle cycle (R1 single cycle)
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         req_valid = 1'b0;
         expect_vec(VECS[i], i);
         @(negedge clk);
         expect_idle("R1 strobe drop");
      end

      // R1: back-to-back requests
      drive(VECS[8]);
      @(negedge clk);
      expect_vec(VECS[8], 100);
      drive(VECS[13]);
      @(negedge clk);
      expect_vec(VECS[13], 101);
      req_valid = 1'b0;

      // R1: inputs with no strobe produce nothing
      req_mode = 3'd5; req_br_cond = 1'b1; req_op0 = 8'h40; req_pc = 16'h1234;
      @(negedge clk);
      expect_idle("R1 no strobe a");
      req_mode = 3'd2; req_op0 = 8'hAB;
      @(negedge clk);
      expect_idle("R1 no strobe b");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule